// File: doc/BRIEF.md
# Mirrored Dual-Read Register File with Stack-Pointer Restore

This block is a 64-word by 32-bit register file. It serves two operand reads and one result write in every clock cycle. It is built from two identical single-read, single-write memory banks. Every write goes into both banks, and each bank feeds one of the two read ports, so the two banks always hold the same contents. A 64-bit operand is stored as two 32-bit words at consecutive addresses: the low half at the lower address and the high half at the next one. The two halves are written in two cycles and can be read back in one cycle through the two ports.

One word address is reserved for the stack pointer. An access to that address reaches the user stack pointer or the supervisor stack pointer, depending on a mode input. Each stack pointer also has a backup copy. An instruction-complete strobe copies both live stack pointers into their backups. An abort strobe copies the backups back into the live stack pointers. The abort lets an instruction that already decremented a stack pointer be restarted after a memory-management fault.

Top module: `dup_regfile`

## Requirements
- R1: After reset, both read outputs are 0, and both stack pointers read as 0.
- R2: A write with `wr_en_i`=1 to any address other than the stack-pointer address (default 29) stores `wr_data_i` in both banks. Either read port can then return that word, and the two ports can read different addresses in the same cycle.
- R3: Reads are synchronous. The word at the read address sampled at a rising edge appears on the read output right after that edge, and one write can complete in the same cycle.
- R4: If a read address equals the write address in the same cycle, the read output shows the new write data (write-through bypass). This applies to the stack-pointer address too.
- R5: A 64-bit value written as low half at address 2k and high half at 2k+1 comes back whole in one cycle when port A reads 2k and port B reads 2k+1.
- R6: An access to the stack-pointer address goes to the user stack pointer when `sup_mode_i`=0 and to the supervisor stack pointer when `sup_mode_i`=1. A write to one stack pointer leaves the other unchanged.
- R7: `commit_i`=1 copies both live stack pointers into their backups. The copy includes a stack-pointer write made in the same cycle.
- R8: `abort_i`=1 loads both live stack pointers from their backups. A write to the stack-pointer address in the same cycle is discarded, while writes to other addresses still take effect. A read of the stack-pointer address in the abort cycle returns the restored value.
- R9: When `commit_i` and `abort_i` are both 1, the abort takes effect and the backups keep their old values. When neither is 1, the backups do not change.
- R10: With `wr_en_i`=0, no stored word and no stack pointer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_addr_i | input | 6 | Read port A address |
| rd_b_addr_i | input | 6 | Read port B address |
| rd_a_data_o | output | 32 | Read port A data, one cycle after the address |
| rd_b_data_o | output | 32 | Read port B data, one cycle after the address |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | 6 | Write address |
| wr_data_i | input | 32 | Write data |
| sup_mode_i | input | 1 | Selects the stack pointer: 0 user, 1 supervisor |
| commit_i | input | 1 | Instruction complete: copy stack pointers into their backups |
| abort_i | input | 1 | Abort: restore stack pointers from their backups |

## Verification
Every read result is due exactly one rising edge after its address is presented. The bench drives all inputs on the falling edge and checks the outputs on the next falling edge, half a cycle after the edge that registered them. Stored words and stack-pointer state become visible the edge after the write, commit or abort. They are therefore checked with a read issued in a later cycle, except for the bypass and abort-cycle cases, which are checked in the same cycle. A full sweep writes all 64 addresses, reads them back on both ports in opposite orders, and compares the results with values computed arithmetically from the address.

// File: rtl/regf_pkg.sv
package regf_pkg;
  localparam int unsigned N_BANKS = 2;
  localparam int unsigned N_SP    = 2;
  typedef enum logic {MODE_USER = 1'b0, MODE_SUP = 1'b1} sp_mode_e;
endpackage

// File: rtl/regf_bank.sv
module regf_bank #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        rdata_o <= '0;
    else if (we_i && waddr_i == raddr_i) rdata_o <= wdata_i;
    else                                rdata_o <= mem[raddr_i];
  end

  // R4: same-cycle write is visible on the read
  a_r4_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i == raddr_i) |=> rdata_o == $past(wdata_i));
endmodule

// File: rtl/regf_sp_ctl.sv
module regf_sp_ctl
  import regf_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_sp_i,
  input  sp_mode_e         mode_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             commit_i,
  input  logic             abort_i,
  output logic [WIDTH-1:0] rd_val_o
);
  logic [WIDTH-1:0] sp_q  [N_SP];
  logic [WIDTH-1:0] bk_q  [N_SP];
  logic [WIDTH-1:0] sp_nx [N_SP];

  always_comb begin
    for (int i = 0; i < N_SP; i++) begin
      if (abort_i)                              sp_nx[i] = bk_q[i];
      else if (wr_sp_i && int'(mode_i) == i)    sp_nx[i] = wdata_i;
      else                                      sp_nx[i] = sp_q[i];
    end
  end

  assign rd_val_o = sp_nx[mode_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_SP; i++) begin
        sp_q[i] <= '0;
        bk_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N_SP; i++) begin
        sp_q[i] <= sp_nx[i];
        if (commit_i && !abort_i) bk_q[i] <= sp_nx[i];
      end
    end
  end

  // R7: after a commit, backups match live
  a_r7_commit_copies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && !abort_i) |=> (bk_q[0] == sp_q[0] && bk_q[1] == sp_q[1]));
  // R8: abort restores live from backup
  a_r8_abort_restores: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (sp_q[0] == $past(bk_q[0]) && sp_q[1] == $past(bk_q[1])));
  // R9: backups hold without a clean commit
  a_r9_backup_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!commit_i || abort_i) |=> ($stable(bk_q[0]) && $stable(bk_q[1])));
  // R6: mode isolation
  a_r6_user_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sp_i && !abort_i && mode_i == MODE_USER) |=> $stable(sp_q[1]));
  a_r6_sup_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sp_i && !abort_i && mode_i == MODE_SUP) |=> $stable(sp_q[0]));
endmodule

// File: rtl/dup_regfile.sv
module dup_regfile
  import regf_pkg::*;
#(
  parameter int unsigned WIDTH   = 32,
  parameter int unsigned DEPTH   = 64,
  parameter int unsigned SP_ADDR = 29,
  localparam int unsigned AW     = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    rd_a_addr_i,
  input  logic [AW-1:0]    rd_b_addr_i,
  output logic [WIDTH-1:0] rd_a_data_o,
  output logic [WIDTH-1:0] rd_b_data_o,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             sup_mode_i,
  input  logic             commit_i,
  input  logic             abort_i
);
  localparam logic [AW-1:0] SP_A = AW'(SP_ADDR);

  logic [AW-1:0]    raddr [N_BANKS];
  logic [WIDTH-1:0] rdata [N_BANKS];
  logic             sel_sp_q [N_BANKS];
  logic [WIDTH-1:0] sp_val, sp_rd_q;
  logic             wr_sp, wr_mem;

  assign raddr[0] = rd_a_addr_i;
  assign raddr[1] = rd_b_addr_i;
  assign wr_sp    = wr_en_i && wr_addr_i == SP_A;
  assign wr_mem   = wr_en_i && wr_addr_i != SP_A;

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    regf_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_bank (
      .clk_i, .rst_ni,
      .we_i(wr_mem), .waddr_i(wr_addr_i), .wdata_i(wr_data_i),
      .raddr_i(raddr[b]), .rdata_o(rdata[b])
    );
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sel_sp_q[b] <= 1'b0;
      else         sel_sp_q[b] <= raddr[b] == SP_A;
    end
  end

  regf_sp_ctl #(.WIDTH(WIDTH)) u_sp (
    .clk_i, .rst_ni,
    .wr_sp_i(wr_sp), .mode_i(sp_mode_e'(sup_mode_i)), .wdata_i(wr_data_i),
    .commit_i, .abort_i, .rd_val_o(sp_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sp_rd_q <= '0;
    else         sp_rd_q <= sp_val;
  end

  assign rd_a_data_o = sel_sp_q[0] ? sp_rd_q : rdata[0];
  assign rd_b_data_o = sel_sp_q[1] ? sp_rd_q : rdata[1];

  // R2: ports reading the same address agree (banks mirrored)
  a_r2_ports_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_a_addr_i == rd_b_addr_i) |=> rd_a_data_o == rd_b_data_o);
endmodule

// File: tb/dup_regfile_bench.sv
module dup_regfile_bench;
  localparam int CLK_P = 10;
  localparam logic [5:0] SPA = 6'd29;

  logic clk = 0, rst_n = 0;
  logic [5:0] ra = 0, rb = 0, wa = 0;
  logic [31:0] qa, qb, wd = 0;
  logic we = 0, md = 0, cm = 0, ab = 0;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  dup_regfile u_dup_regfile (
    .clk_i(clk), .rst_ni(rst_n), .rd_a_addr_i(ra), .rd_b_addr_i(rb),
    .rd_a_data_o(qa), .rd_b_data_o(qb), .wr_en_i(we), .wr_addr_i(wa),
    .wr_data_i(wd), .sup_mode_i(md), .commit_i(cm), .abort_i(ab));

  function automatic logic [31:0] pat(int a);
    return 32'h9E3779B9 * (a + 1) ^ 32'h0F0F00FF;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, outputs valid at the following negedge
  task automatic cyc(logic w, logic [5:0] a, logic [31:0] d, logic [5:0] xa,
                     logic [5:0] xb, logic m, logic c, logic x);
    we = w; wa = a; wd = d; ra = xa; rb = xb; md = m; cm = c; ab = x;
    @(negedge clk);
    we = 0; cm = 0; ab = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 reset A", qa, 0);
    chk("R1 reset B", qb, 0);
    rst_n = 1;
    cyc(0, 0, 0, SPA, SPA, 0, 0, 0);
    chk("R1 user sp", qa, 0);
    cyc(0, 0, 0, SPA, SPA, 1, 0, 0);
    chk("R1 sup sp", qb, 0);

    // R2/R3 sweep
    for (int a = 0; a < 64; a++) cyc(1, 6'(a), pat(a), 0, 0, 0, 0, 0);
    for (int a = 0; a < 64; a++) begin
      cyc(0, 0, 0, 6'(a), 6'(63 - a), 0, 0, 0);
      chk("R2 R3 port A", qa, pat(a));
      chk("R2 R3 port B", qb, pat(63 - a));
    end

    // R3: read and unrelated write in the same cycle
    cyc(1, 6'd3, 32'h1234_5678, 6'd4, 6'd5, 0, 0, 0);
    chk("R3 read during write", qa, pat(4));
    cyc(0, 0, 0, 6'd3, 6'd3, 0, 0, 0);
    chk("R3 written word", qb, 32'h1234_5678);

    // R10
    we = 0; wa = 6'd5; wd = 32'hDEAD_BEEF; md = 0;
    @(negedge clk);
    wa = SPA; @(negedge clk);
    cyc(0, 0, 0, 6'd5, SPA, 0, 0, 0);
    chk("R10 word kept", qa, pat(5));
    chk("R10 sp kept", qb, pat(29));

    // R4
    cyc(1, 6'd7, 32'hCAFE_0007, 6'd7, 6'd7, 0, 0, 0);
    chk("R4 bypass A", qa, 32'hCAFE_0007);
    chk("R4 bypass B", qb, 32'hCAFE_0007);
    cyc(1, SPA, 32'h5500_0001, SPA, 6'd0, 1, 0, 0);
    chk("R4 sp bypass", qa, 32'h5500_0001);

    // R5
    cyc(1, 6'd10, 32'h89AB_CDEF, 0, 0, 0, 0, 0);
    cyc(1, 6'd11, 32'h0123_4567, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 6'd10, 6'd11, 0, 0, 0);
    chk("R5 low half", qa, 32'h89AB_CDEF);
    chk("R5 high half", qb, 32'h0123_4567);

    // R6
    cyc(0, 0, 0, SPA, SPA, 1, 0, 0);
    chk("R6 sup sp", qa, 32'h5500_0001);
    cyc(0, 0, 0, SPA, SPA, 0, 0, 0);
    chk("R6 user sp untouched", qa, pat(29));

    // R7: commit with same-cycle user sp write
    cyc(1, SPA, 32'h0000_1000, 0, 0, 0, 1, 0);
    cyc(1, SPA, 32'h0000_0FFC, 0, 0, 0, 0, 0);
    cyc(1, SPA, 32'h7700_0000, 0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, SPA, SPA, 0, 0, 0);
    chk("R7 user backup", qa, 32'h0000_1000);
    cyc(0, 0, 0, SPA, SPA, 1, 0, 0);
    chk("R7 sup backup", qa, 32'h5500_0001);

    // R8
    cyc(1, SPA, 32'h0000_0FF8, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, SPA, 6'd0, 0, 0, 1);
    chk("R8 read in abort cycle", qa, 32'h0000_1000);
    cyc(1, SPA, 32'hBAD0_BAD0, 0, 0, 0, 0, 1);
    cyc(1, 6'd40, 32'h4040_4040, SPA, SPA, 0, 0, 1);
    chk("R8 sp write dropped", qa, 32'h0000_1000);
    cyc(0, 0, 0, 6'd40, 6'd41, 0, 0, 0);
    chk("R8 other write kept", qa, 32'h4040_4040);
    chk("R8 neighbour", qb, pat(41));

    // R9
    cyc(1, SPA, 32'h0000_0F00, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 1, 1);
    cyc(0, 0, 0, SPA, SPA, 0, 0, 0);
    chk("R9 abort wins", qa, 32'h0000_1000);
    cyc(1, SPA, 32'h0000_0E00, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    cyc(0, 0, 0, SPA, SPA, 0, 0, 0);
    chk("R9 backup kept", qa, 32'h0000_1000);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule